// File: doc/BRIEF.md
# Serial Load and Unload Sequencer

This block moves a fixed-size data set from a serial receiver into memory, starts a processor, and returns the processor's result over a serial line. During the load phase it accepts bytes one at a time from an external UART receiver. It writes each byte to the next memory address and clears the receiver after each byte. When the configured number of bytes has arrived, it raises a completion flag that lets the processor start.

The block then waits for the processor's end-of-operation input. It reads a result region of configurable base and length from a memory with one cycle of read latency. It sends each byte through its own UART transmitter as a ten-bit frame. The transmitter's bit timing comes from an internal divider. The divider toggles a bit clock each time a cycle counter reaches its limit, so one bit lasts twice that limit in clock cycles. The sequencer waits for each frame to finish before it reads the next byte. After the last byte it drops the completion flag, rewinds its address counter, and returns to the load phase. A single address counter serves both phases.

Top module: `xfer_seq`

## Requirements
- R1: Loaded bytes go to memory addresses 0, 1, 2 and upward, in arrival order. The address output rises by exactly one in the cycle after each receiver clear pulse.
- R2: Each accepted byte produces exactly one cycle of `mem_we`. The next cycle produces exactly one cycle of `rx_clear`.
- R3: `load_done` stays low until the last of `LOAD_COUNT` bytes has been stored. It rises two cycles after that byte's `rx_clear` pulse and stays high until the unload phase ends.
- R4: While `load_done` is high, `rx_ready` is ignored. No memory write happens and memory contents stay unchanged.
- R5: `txd` stays high (idle) throughout reset, the load phase, and the wait for `proc_done`.
- R6: After `proc_done`, the bytes at addresses `RES_BASE` through `RES_BASE+RES_COUNT-1` are sent in increasing address order. Each frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. Every bit lasts 2*`DIV_COUNT` clock cycles.
- R7: A new frame starts only after the previous frame's stop bit has completed. Frames never overlap.
- R8: After the last frame, `load_done` falls and `mem_addr` returns to 0 in the same cycle. A following load writes again from address 0.
- R9: During and right after reset, `txd` is 1, and `load_done`, `mem_we`, `rx_clear` and `mem_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_ready | input | 1 | Receiver holds a new byte |
| rx_byte | input | 8 | Byte from the receiver |
| rx_clear | output | 1 | One-cycle pulse that releases the receiver's byte |
| mem_addr | output | AW | Shared memory address for writes and reads |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the address |
| load_done | output | 1 | Load complete; processor may run |
| proc_done | input | 1 | Processor end-of-operation |
| txd | output | 1 | Serial transmit line, idle high |

## Verification
A byte held on `rx_ready` is written at the clock edge that ends the write cycle, two edges after the bench raises it. The clear pulse follows in the next cycle. The bench polls on falling edges until it sees the clear, so every memory check falls after the write has landed. `load_done` is due two edges after the final clear, and the bench samples it there. Transmit frames are decoded from the first falling edge seen on `txd`. Each bit is then sampled in its middle, half a bit period after the frame edge and then one full period (2*`DIV_COUNT` cycles) apart. This way, a wrong bit length, a wrong bit order or a clipped stop bit changes the decoded byte or the framing bits.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [2:0] {
        ST_RX_WAIT   = 3'd0,
        ST_STORE     = 3'd1,
        ST_STEP      = 3'd2,
        ST_LOADED    = 3'd3,
        ST_SEND      = 3'd4,
        ST_UNSEND    = 3'd5,
        ST_FINISH    = 3'd6,
        ST_PROC_WAIT = 3'd7
    } seq_state_e;

    localparam int FRAME_BITS = 10;
    localparam int DATA_BITS  = 8;

    typedef struct packed {
        logic [FRAME_BITS-1:0] bits;
        logic [3:0]            idx;
        logic                  busy;
    } tx_shift_t;

    // Frame is shifted out from bit 0: start (0), data LSB first, stop (1).
    function automatic logic [FRAME_BITS-1:0] build_frame(input logic [DATA_BITS-1:0] d);
        return {1'b1, d, 1'b0};
    endfunction

endpackage

// File: rtl/bit_clk_div.sv
module bit_clk_div #(
    parameter int DIV_COUNT = 5208
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV_COUNT < 2) ? 1 : $clog2(DIV_COUNT);

    logic [CW-1:0] cnt;
    logic          bclk;
    logic          at_limit;

    assign at_limit = (cnt == CW'(DIV_COUNT - 1));
    // Tick marks the rising transition of the divided clock.
    assign tick = run && at_limit && !bclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            bclk <= 1'b1;
        end else if (at_limit) begin
            cnt  <= '0;
            bclk <= ~bclk;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
    import xfer_pkg::*;
#(
    parameter int DIV_COUNT = 5208
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       send,
    input  logic [7:0] data,
    output logic       txd,
    output logic       busy
);
    tx_shift_t sh;
    logic      tick;

    bit_clk_div #(.DIV_COUNT(DIV_COUNT)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (sh.busy),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sh.bits <= '1;
            sh.idx  <= '0;
            sh.busy <= 1'b0;
        end else if (!sh.busy) begin
            if (send) begin
                sh.bits <= build_frame(data);
                sh.idx  <= '0;
                sh.busy <= 1'b1;
            end
        end else if (tick) begin
            sh.bits <= {1'b1, sh.bits[FRAME_BITS-1:1]};
            if (sh.idx == 4'(FRAME_BITS - 1)) begin
                sh.busy <= 1'b0;
            end else begin
                sh.idx <= sh.idx + 4'd1;
            end
        end
    end

    assign txd  = sh.bits[0];
    assign busy = sh.busy;

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import xfer_pkg::*;
#(
    parameter int AW         = 16,
    parameter int LOAD_COUNT = 1024,
    parameter int RES_BASE   = 1024,
    parameter int RES_COUNT  = 256,
    parameter int DIV_COUNT  = 5208
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_ready,
    input  logic [7:0]    rx_byte,
    output logic          rx_clear,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          mem_we,
    input  logic [7:0]    mem_rdata,
    output logic          load_done,
    input  logic          proc_done,
    output logic          txd
);
    localparam int MAXC = (LOAD_COUNT > RES_COUNT) ? LOAD_COUNT : RES_COUNT;
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_e    state;
    logic [AW-1:0] addr;
    logic [CW-1:0] cnt;
    logic [7:0]    wbyte;
    logic          rd_wait;
    logic          ldone;
    logic          tx_busy;
    logic          tx_send;

    assign tx_send = (state == ST_SEND) && !rd_wait && !tx_busy;

    uart_tx_frame #(.DIV_COUNT(DIV_COUNT)) u_tx (
        .clk  (clk),
        .rst  (rst),
        .send (tx_send),
        .data (mem_rdata),
        .txd  (txd),
        .busy (tx_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_RX_WAIT;
            addr    <= '0;
            cnt     <= '0;
            wbyte   <= '0;
            rd_wait <= 1'b0;
            ldone   <= 1'b0;
        end else begin
            unique case (state)
                ST_RX_WAIT: begin
                    if (rx_ready) begin
                        wbyte <= rx_byte;
                        state <= ST_STORE;
                    end
                end
                ST_STORE: state <= ST_STEP;
                ST_STEP: begin
                    addr <= addr + AW'(1);
                    if (cnt == CW'(LOAD_COUNT - 1)) begin
                        cnt   <= '0;
                        state <= ST_LOADED;
                    end else begin
                        cnt   <= cnt + CW'(1);
                        state <= ST_RX_WAIT;
                    end
                end
                ST_LOADED: begin
                    ldone <= 1'b1;
                    addr  <= AW'(RES_BASE);
                    cnt   <= '0;
                    state <= ST_PROC_WAIT;
                end
                ST_PROC_WAIT: begin
                    if (proc_done) state <= ST_SEND;
                end
                ST_SEND: begin
                    if (rd_wait) begin
                        rd_wait <= 1'b0;
                    end else if (!tx_busy) begin
                        state <= ST_UNSEND;
                    end
                end
                ST_UNSEND: begin
                    if (!tx_busy) begin
                        if (cnt == CW'(RES_COUNT - 1)) begin
                            state <= ST_FINISH;
                        end else begin
                            addr    <= addr + AW'(1);
                            cnt     <= cnt + CW'(1);
                            rd_wait <= 1'b1;
                            state   <= ST_SEND;
                        end
                    end
                end
                ST_FINISH: begin
                    ldone <= 1'b0;
                    addr  <= '0;
                    cnt   <= '0;
                    state <= ST_RX_WAIT;
                end
                default: state <= ST_RX_WAIT;
            endcase
        end
    end

    assign mem_we    = (state == ST_STORE);
    assign rx_clear  = (state == ST_STEP);
    assign mem_wdata = wbyte;
    assign mem_addr  = addr;
    assign load_done = ldone;

endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_we,
    input logic          rx_clear,
    input logic [AW-1:0] mem_addr,
    input logic          load_done,
    input logic          txd
);
    assert_we_single_R2: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    assert_clear_follows_R2: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> rx_clear);

    assert_addr_step_R1: assert property (@(posedge clk) disable iff (rst)
        rx_clear |=> (mem_addr == $past(mem_addr) + AW'(1)));

    assert_done_after_clear_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(load_done) |-> $past(rx_clear, 2));

    assert_no_write_loaded_R4: assert property (@(posedge clk) disable iff (rst)
        load_done |-> !mem_we);

    assert_idle_line_R5: assert property (@(posedge clk) disable iff (rst)
        !load_done |-> txd);

    assert_rewind_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(load_done) |-> (mem_addr == '0));
endmodule

bind xfer_seq xfer_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_we    (mem_we),
    .rx_clear  (rx_clear),
    .mem_addr  (mem_addr),
    .load_done (load_done),
    .txd       (txd)
);

// File: tb/sim_xfer_seq.sv
module sim_xfer_seq;
    localparam int AW        = 8;
    localparam int LOADN     = 4;
    localparam int RBASE     = 8;
    localparam int RCOUNT    = 3;
    localparam int DIV       = 3;
    localparam int BP        = 2 * DIV;
    localparam int WATCHDOG  = 20000;

    localparam logic [7:0] LOAD_VEC [LOADN]  = '{8'h3C, 8'hA1, 8'h00, 8'hFF};
    localparam logic [7:0] RES_VEC  [RCOUNT] = '{8'h55, 8'hC3, 8'h81};
    localparam logic [7:0] FILL = 8'h5A;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx_ready = 1'b0;
    logic [7:0]    rx_byte = '0;
    logic          rx_clear;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_we;
    logic [7:0]    mem_rdata;
    logic          load_done;
    logic          proc_done = 1'b0;
    logic          txd;

    logic [7:0] mem [256];
    int wr_cnt;
    int clr_cnt;
    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    xfer_seq #(.AW(AW), .LOAD_COUNT(LOADN), .RES_BASE(RBASE),
               .RES_COUNT(RCOUNT), .DIV_COUNT(DIV)) u0 (
        .clk(clk), .rst(rst), .rx_ready(rx_ready), .rx_byte(rx_byte),
        .rx_clear(rx_clear), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .load_done(load_done),
        .proc_done(proc_done), .txd(txd)
    );

    // Memory model: synchronous write, one-cycle read latency.
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= FILL;
            for (int k = 0; k < RCOUNT; k++) mem[RBASE + k] <= RES_VEC[k];
            wr_cnt  <= 0;
            clr_cnt <= 0;
        end else begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (rx_clear) clr_cnt <= clr_cnt + 1;
        end
        mem_rdata <= mem[mem_addr];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    // Receiver model: hold the byte until the clear pulse is seen.
    task automatic rx_push(input logic [7:0] b);
        int n;
        @(negedge clk);
        rx_byte  = b;
        rx_ready = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rx_clear && n < 50);
        check(rx_clear, "R2 clear pulse", n, 3);
        rx_ready = 1'b0;
    endtask

    // Decode one frame by mid-bit sampling from the first low seen on txd.
    task automatic rx_frame(output logic [7:0] b, output logic st, output logic sp);
        int n = 0;
        while (txd && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (BP / 2) @(negedge clk);
        st = txd;
        for (int i = 0; i < 8; i++) begin
            repeat (BP) @(negedge clk);
            b[i] = txd;
        end
        repeat (BP) @(negedge clk);
        sp = txd;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R6 watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [7:0] got;
        logic st, sp;
        int lows;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(txd == 1'b1, "R9 txd", txd, 1);
        check(load_done == 1'b0 && mem_we == 1'b0 && rx_clear == 1'b0,
              "R9 outputs", {load_done, mem_we, rx_clear}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(mem_addr == '0, "R9 addr", mem_addr, 0);

        // Vector walk: load phase (R1, R3)
        for (int i = 0; i < LOADN; i++) begin
            check(load_done == 1'b0, "R3 early done", load_done, 0);
            rx_push(LOAD_VEC[i]);
            check(mem[i] == LOAD_VEC[i], "R1 stored byte", mem[i], LOAD_VEC[i]);
        end
        @(negedge clk);
        @(negedge clk);
        check(load_done == 1'b1, "R3 done rise", load_done, 1);
        check(wr_cnt == LOADN, "R2 write count", wr_cnt, LOADN);
        check(clr_cnt == LOADN, "R2 clear count", clr_cnt, LOADN);

        // R4 and R5: extra byte ignored, line idle before proc_done
        rx_byte  = 8'hEE;
        rx_ready = 1'b1;
        lows = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (!txd) lows++;
        end
        rx_ready = 1'b0;
        @(negedge clk);
        check(wr_cnt == LOADN, "R4 write ignored", wr_cnt, LOADN);
        check(mem[LOADN] == FILL, "R4 memory untouched", mem[LOADN], FILL);
        check(lows == 0, "R5 idle before start", lows, 0);

        // Unload phase (R6, R7)
        proc_done = 1'b1;
        for (int k = 0; k < RCOUNT; k++) begin
            rx_frame(got, st, sp);
            proc_done = 1'b0;
            check(st == 1'b0, "R6 start bit", st, 0);
            check(got == RES_VEC[k], "R6 byte order", got, RES_VEC[k]);
            check(sp == 1'b1, "R7 stop bit", sp, 1);
        end

        // R8: rewind and reload
        lows = 0;
        while (load_done && lows < 200) begin
            @(negedge clk);
            lows++;
        end
        check(load_done == 1'b0, "R8 done fall", load_done, 0);
        check(mem_addr == '0, "R8 addr rewind", mem_addr, 0);
        check(txd == 1'b1, "R5 idle after", txd, 1);
        rx_push(8'h17);
        rx_push(8'h29);
        check(mem[0] == 8'h17 && mem[1] == 8'h29, "R8 reload from 0",
              {mem[0], mem[1]}, 16'h1729);
        summary();
    end
endmodule